// File: doc/BRIEF.md
# Dual Programmable Interval Timer

This peripheral holds up to two independent 32-bit timer channels behind a word-wide register port. Software programs a start value and a control word into a channel. The channel then counts on every cycle in which the shared `tick` clock-enable is high. The count runs down towards zero or up towards all-ones, as the direction bit selects. When the count passes its terminal value, the channel raises a pending flag. It then either reloads its start value and keeps running, or it halts.

Each channel owns a window of four 32-bit words, and the windows sit 0x10 bytes apart. The pending flags, each gated by its channel's interrupt-enable bit, are ORed onto a single interrupt line. The `NUM_CH` parameter can trim the block to one channel. In that case only the first window responds.

Top module: `dual_timer_unit`

## Requirements
- R1: Channel c occupies byte offsets 0x10*c to 0x10*c+0xC. Word 0 (offset 0x0) is control/status, word 1 (0x4) is the start value, and word 2 (0x8) is the live count. Word 3 (0xC) always reads zero, and writes to it have no effect.
- R2: A control/status write stores data bits 10:0, apart from the pending flag (bit 8). A read returns those 11 bits, with bits 31:11 zero. Bits 0, 2, 3, 9 and 10 are only stored.
- R3: The pending flag (bit 8) is cleared by a control/status write that has bit 8 at 1. A write with bit 8 at 0 leaves it unchanged, and no write ever sets it. If the channel expires in the same cycle as a clearing write, the flag stays set.
- R4: A control/status write with bit 7 (enable) at 1 copies the start value into the count and starts the channel. A write with bit 7 at 0 stops the channel. If that write also has bit 5 (load) at 1, it copies the start value into the count.
- R5: With bit 1 at 1 (down), a running channel decrements the count by one on each cycle in which `tick` is high. The tick seen while the count is zero is the expiry.
- R6: With bit 1 at 0 (up), a running channel increments the count by one on each cycle in which `tick` is high. The tick seen while the count is all-ones is the expiry.
- R7: On expiry the channel sets its pending flag. If bit 4 (auto-reload) is 1, the count takes the start value and the channel keeps running. Otherwise the channel halts and holds the terminal count.
- R8: `irq` is the OR, over the present channels, of pending flag AND bit 6 (interrupt enable). It follows the register state in the cycle after a write or an expiry.
- R9: A write to the start value leaves the live count unchanged. The new value is used only at the next enable write, load write or auto-reload.
- R10: With `NUM_CH`=1, the window at 0x10 reads zero and ignores writes, and it never contributes to `irq`.
- R11: After reset all registers read zero, no channel runs and `irq` is low.
- R12: A request is acted on only when `req_valid` is high and `req_addr[1:0]` is zero. `rsp_rdata` is the addressed word in the same cycle as a read request, and zero in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable shared by all channels |
| req_valid | input | 1 | Register request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (5) | Byte address |
| req_wdata | input | DW (32) | Write data |
| rsp_rdata | output | DW (32) | Read data, combinational |
| irq | output | 1 | Shared interrupt |

## Verification
The bench builds two copies side by side from the same stimulus. One uses the default `NUM_CH`=2 and the other uses `NUM_CH`=1, with `AW`=5 and `DW`=32 in both. The two-channel copy shows that the windows stay independent and that a second channel's flag reaches the ORed interrupt. The one-channel copy, fed the same writes to 0x10-0x1C, shows that the absent window reads zero and never raises `irq`. Start values near all-ones in up mode bring the 32-bit terminal count within a few ticks.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

  // control/status field positions
  localparam int CTRL_W  = 11;
  localparam int B_MODE  = 0;
  localparam int B_DOWN  = 1;
  localparam int B_GEN   = 2;
  localparam int B_CAPT  = 3;
  localparam int B_AREL  = 4;
  localparam int B_LOAD  = 5;
  localparam int B_IE    = 6;
  localparam int B_EN    = 7;
  localparam int B_PEND  = 8;
  localparam int B_PWM   = 9;
  localparam int B_ALL   = 10;

  // word index inside one channel window
  typedef enum logic [1:0] {
    W_CTRL  = 2'd0,
    W_START = 2'd1,
    W_COUNT = 2'd2,
    W_RSVD  = 2'd3
  } word_e;

endpackage

// File: rtl/dtmr_decode.sv
module dtmr_decode
  import dtmr_pkg::*;
#(
  parameter int AW     = 5,
  parameter int NUM_CH = 2
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  output logic [NUM_CH-1:0] wr_sel,
  output logic [NUM_CH-1:0] rd_sel,
  output word_e             word
);

  localparam int IW = AW - 4;

  logic acc_ok;

  // only aligned accesses are decoded
  assign acc_ok = req_valid && (req_addr[1:0] == 2'b00);
  assign word   = word_e'(req_addr[3:2]);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
    logic hit;
    assign hit       = acc_ok && (req_addr[AW-1:4] == IW'(i));
    assign wr_sel[i] = hit && req_write;
    assign rd_sel[i] = hit && !req_write;
  end

endmodule

// File: rtl/dtmr_channel.sv
module dtmr_channel
  import dtmr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  word_e             word,
  input  logic [DW-1:0]     wdata,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [DW-1:0]     start_q,
  output logic [DW-1:0]     cnt_q,
  output logic              irq_req
);

  localparam logic [CTRL_W-1:0] PEND_MASK = CTRL_W'(1) << B_PEND;

  logic [CTRL_W-1:0] ctrl_d;
  logic [DW-1:0]     start_d;
  logic [DW-1:0]     cnt_d;
  logic              run_q;
  logic              run_d;
  logic              at_term;
  logic              advance;
  logic              expire;
  logic              pend_keep;

  // terminal count depends on direction
  always_comb begin
    at_term = ctrl_q[B_DOWN] ? (cnt_q == '0) : (cnt_q == '1);
    advance = run_q && tick;
    expire  = advance && at_term;
  end

  // next-state logic: counting first, then a register write overrides
  always_comb begin
    ctrl_d    = ctrl_q;
    start_d   = start_q;
    cnt_d     = cnt_q;
    run_d     = run_q;
    pend_keep = ctrl_q[B_PEND];

    if (advance) begin
      if (at_term) begin
        pend_keep = 1'b1;
        if (ctrl_q[B_AREL]) begin
          cnt_d = start_q;
        end else begin
          run_d = 1'b0;
        end
      end else if (ctrl_q[B_DOWN]) begin
        cnt_d = cnt_q - 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    ctrl_d[B_PEND] = pend_keep;

    if (wr_en) begin
      unique case (word)
        W_CTRL: begin
          ctrl_d = wdata[CTRL_W-1:0] & ~PEND_MASK;
          // write-one-to-clear, expiry in the same cycle wins
          ctrl_d[B_PEND] = wdata[B_PEND] ? expire : pend_keep;
          if (wdata[B_EN]) begin
            cnt_d = start_q;
            run_d = 1'b1;
          end else begin
            run_d = 1'b0;
            if (wdata[B_LOAD]) begin
              cnt_d = start_q;
            end
          end
        end
        W_START: start_d = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      start_q <= '0;
      cnt_q   <= '0;
      run_q   <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      start_q <= start_d;
      cnt_q   <= cnt_d;
      run_q   <= run_d;
    end
  end

  assign irq_req = ctrl_q[B_PEND] & ctrl_q[B_IE];

endmodule

// File: rtl/dtmr_rdmux.sv
module dtmr_rdmux
  import dtmr_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DW     = 32
) (
  input  logic [NUM_CH-1:0]             rd_sel,
  input  word_e                         word,
  input  logic [NUM_CH-1:0][CTRL_W-1:0] ctrl_all,
  input  logic [NUM_CH-1:0][DW-1:0]     start_all,
  input  logic [NUM_CH-1:0][DW-1:0]     cnt_all,
  output logic [DW-1:0]                 rdata
);

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rd_sel[i]) begin
        unique case (word)
          W_CTRL:  rdata = rdata | {{(DW-CTRL_W){1'b0}}, ctrl_all[i]};
          W_START: rdata = rdata | start_all[i];
          W_COUNT: rdata = rdata | cnt_all[i];
          default: rdata = rdata;
        endcase
      end
    end
  end

endmodule

// File: rtl/dual_timer_unit.sv
module dual_timer_unit
  import dtmr_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int AW     = 5,
  parameter int DW     = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] rsp_rdata,
  output logic          irq
);

  logic [NUM_CH-1:0]             wr_sel;
  logic [NUM_CH-1:0]             rd_sel;
  word_e                         word;
  logic [NUM_CH-1:0][CTRL_W-1:0] ctrl_all;
  logic [NUM_CH-1:0][DW-1:0]     start_all;
  logic [NUM_CH-1:0][DW-1:0]     cnt_all;
  logic [NUM_CH-1:0]             irq_req;

  dtmr_decode #(.AW(AW), .NUM_CH(NUM_CH)) u_dec (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .wr_sel    (wr_sel),
    .rd_sel    (rd_sel),
    .word      (word)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    dtmr_channel #(.DW(DW)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .wr_en   (wr_sel[i]),
      .word    (word),
      .wdata   (req_wdata),
      .ctrl_q  (ctrl_all[i]),
      .start_q (start_all[i]),
      .cnt_q   (cnt_all[i]),
      .irq_req (irq_req[i])
    );
  end

  dtmr_rdmux #(.NUM_CH(NUM_CH), .DW(DW)) u_rd (
    .rd_sel    (rd_sel),
    .word      (word),
    .ctrl_all  (ctrl_all),
    .start_all (start_all),
    .cnt_all   (cnt_all),
    .rdata     (rsp_rdata)
  );

  assign irq = |irq_req;

endmodule

// File: rtl/dtmr_chk.sv
module dtmr_chk #(
  parameter int NUM_CH = 2,
  parameter int AW     = 5,
  parameter int DW     = 32
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      tick,
  input logic                      req_valid,
  input logic                      req_write,
  input logic [AW-1:0]             req_addr,
  input logic [DW-1:0]             rsp_rdata,
  input logic                      irq,
  input logic [NUM_CH-1:0][DW-1:0] cnt_all
);

  logic rd_req;
  assign rd_req = req_valid && !req_write && (req_addr[1:0] == 2'b00);

  // R11
  always @(posedge clk) begin
    if (!rst_n) begin
      irq_reset_low_chk: assert (irq == 1'b0);
    end
  end

  // R12
  rdata_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |-> (rsp_rdata == '0));

  // R2
  ctrl_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && req_addr[3:2] == 2'd0) |-> (rsp_rdata[DW-1:11] == '0));

  // R1
  rsvd_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && req_addr[3:2] == 2'd3) |-> (rsp_rdata == '0));

  // R8
  irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(tick || (req_valid && req_write)));

  // R9
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !(req_valid && req_write)) |=> $stable(cnt_all));

endmodule

bind dual_timer_unit dtmr_chk #(.NUM_CH(NUM_CH), .AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .rsp_rdata (rsp_rdata),
  .irq       (irq),
  .cnt_all   (cnt_all)
);

// File: tb/dual_timer_unit_test.sv
`timescale 1ns/1ps
module dual_timer_unit_test;

  logic        clk;
  logic        rst_n;
  logic        tick;
  logic        req_valid;
  logic        req_write;
  logic [4:0]  req_addr;
  logic [31:0] req_wdata;
  logic [31:0] rsp_rdata;
  logic [31:0] rsp_rdata1;
  logic        irq;
  logic        irq1;

  int vectors;
  int errors;

  // behavioural reference state
  logic [10:0] m_ctrl [2];
  logic [31:0] m_start[2];
  logic [31:0] m_cnt  [2];
  bit          m_run  [2];

  initial clk = 1'b0;
  always #2 clk = ~clk;

  dual_timer_unit #(.NUM_CH(2), .AW(5), .DW(32)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .irq(irq)
  );

  dual_timer_unit #(.NUM_CH(1), .AW(5), .DW(32)) u_single (
    .clk(clk), .rst_n(rst_n), .tick(tick), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata1), .irq(irq1)
  );

  function automatic logic [31:0] exp_read(bit single);
    int c;
    if (!req_valid || req_write || req_addr[1:0] != 2'b00) return 32'h0;
    c = int'(req_addr[4]);
    if (single && c == 1) return 32'h0;
    case (req_addr[3:2])
      2'd0:    return {21'h0, m_ctrl[c]};
      2'd1:    return m_start[c];
      2'd2:    return m_cnt[c];
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic exp_irq(bit single);
    logic r;
    r = m_ctrl[0][8] & m_ctrl[0][6];
    if (!single) r = r | (m_ctrl[1][8] & m_ctrl[1][6]);
    return r;
  endfunction

  // advance the reference by one clock with the inputs now applied
  task automatic model_clock();
    for (int c = 0; c < 2; c++) begin
      bit          wr_here;
      bit          fired;
      bit          pend;
      logic [31:0] nxt_cnt;
      bit          nxt_run;
      fired   = 0;
      pend    = m_ctrl[c][8];
      nxt_cnt = m_cnt[c];
      nxt_run = m_run[c];
      wr_here = req_valid && req_write && req_addr[1:0] == 2'b00 &&
                int'(req_addr[4]) == c;
      if (m_run[c] && tick) begin
        if (m_ctrl[c][1]) begin
          if (m_cnt[c] == 32'h0) fired = 1; else nxt_cnt = m_cnt[c] - 1;
        end else begin
          if (m_cnt[c] == 32'hFFFF_FFFF) fired = 1; else nxt_cnt = m_cnt[c] + 1;
        end
        if (fired) begin
          pend = 1;
          if (m_ctrl[c][4]) nxt_cnt = m_start[c]; else nxt_run = 0;
        end
      end
      if (wr_here && req_addr[3:2] == 2'd0) begin
        if (req_wdata[8]) pend = fired;
        if (req_wdata[7]) begin
          nxt_cnt = m_start[c];
          nxt_run = 1;
        end else begin
          nxt_run = 0;
          if (req_wdata[5]) nxt_cnt = m_start[c];
        end
        m_ctrl[c] = req_wdata[10:0];
      end
      m_ctrl[c][8] = pend;
      if (wr_here && req_addr[3:2] == 2'd1) m_start[c] = req_wdata;
      m_cnt[c] = nxt_cnt;
      m_run[c] = nxt_run;
    end
  endtask

  task automatic compare(input string tag);
    logic [31:0] e0, e1;
    logic        i0, i1;
    bit          bad;
    e0 = exp_read(0); e1 = exp_read(1);
    i0 = exp_irq(0);  i1 = exp_irq(1);
    bad = 0;
    vectors++;
    if (rsp_rdata !== e0) begin
      bad = 1;
      $display("FAIL %s rdata addr=%h actual=%h expected=%h", tag, req_addr, rsp_rdata, e0);
    end
    if (irq !== i0) begin
      bad = 1;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, i0);
    end
    if (rsp_rdata1 !== e1) begin
      bad = 1;
      $display("FAIL %s single-channel rdata addr=%h actual=%h expected=%h", tag, req_addr, rsp_rdata1, e1);
    end
    if (irq1 !== i1) begin
      bad = 1;
      $display("FAIL %s single-channel irq actual=%b expected=%b", tag, irq1, i1);
    end
    if (bad) errors++;
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(input string tag, input logic v, input logic w,
                      input logic [4:0] a, input logic [31:0] d, input logic t);
    req_valid = v; req_write = w; req_addr = a; req_wdata = d; tick = t;
    #1;
    compare(tag);
    @(posedge clk);
    #0.5;
    model_clock();
    @(negedge clk);
  endtask

  task automatic wr(input string tag, input logic [4:0] a, input logic [31:0] d, input logic t);
    step(tag, 1'b1, 1'b1, a, d, t);
  endtask

  task automatic rd(input string tag, input logic [4:0] a, input logic t);
    step(tag, 1'b1, 1'b0, a, 32'h0, t);
  endtask

  task automatic run_rd(input string tag, input logic [4:0] a, input int n);
    for (int k = 0; k < n; k++) rd(tag, a, 1'b1);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    vectors = 0; errors = 0;
    rst_n = 1'b0; tick = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0;
    for (int c = 0; c < 2; c++) begin
      m_ctrl[c] = '0; m_start[c] = '0; m_cnt[c] = '0; m_run[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state of every word
    for (int a = 0; a < 32; a += 4) rd("R11", 5'(a), 1'b0);

    // R12 strobe low and misaligned requests are ignored
    step("R12", 1'b0, 1'b1, 5'h04, 32'h55, 1'b0);
    wr("R12", 5'h05, 32'h77, 1'b0);
    rd("R12", 5'h04, 1'b0);
    rd("R12", 5'h06, 1'b0);

    // R1 reserved word and window separation
    wr("R1", 5'h0C, 32'hDEAD_BEEF, 1'b0);
    rd("R1", 5'h0C, 1'b0);
    wr("R1", 5'h14, 32'h0000_AAAA, 1'b0);
    rd("R1", 5'h04, 1'b0);
    rd("R10", 5'h14, 1'b0);

    // R2 control mask, stored-only bits
    wr("R2", 5'h00, 32'hFFFF_FF5F, 1'b0);
    rd("R2", 5'h00, 1'b0);
    wr("R2", 5'h00, 32'h0, 1'b0);

    // R5 down count with stop at expiry (R7), interrupt (R8)
    wr("R5", 5'h04, 32'd5, 1'b0);
    wr("R5", 5'h00, 32'h0000_00C2, 1'b0);
    run_rd("R5", 5'h08, 8);
    run_rd("R7", 5'h08, 3);

    // R3 write with flag bit clear keeps it, with it set clears it
    wr("R3", 5'h00, 32'h0000_0042, 1'b0);
    rd("R3", 5'h00, 1'b0);
    wr("R3", 5'h00, 32'h0000_0142, 1'b0);
    rd("R3", 5'h00, 1'b0);

    // R4 load bit copies start value without running
    wr("R4", 5'h04, 32'h0000_1234, 1'b0);
    wr("R4", 5'h00, 32'h0000_0020, 1'b0);
    run_rd("R4", 5'h08, 3);

    // R7 auto-reload with gapped ticks, R9 start write mid-run
    wr("R7", 5'h04, 32'd3, 1'b0);
    wr("R7", 5'h00, 32'h0000_00D2, 1'b0);
    for (int k = 0; k < 12; k++) rd("R7", 5'h08, 1'(k % 3 != 2));
    wr("R9", 5'h04, 32'd7, 1'b1);
    run_rd("R9", 5'h08, 14);
    wr("R7", 5'h00, 32'h0000_0100, 1'b0);

    // R6 up count on channel 1, absent in the single-channel copy (R10)
    wr("R6", 5'h14, 32'hFFFF_FFFA, 1'b0);
    wr("R6", 5'h10, 32'h0000_00C0, 1'b0);
    run_rd("R6", 5'h18, 9);
    rd("R10", 5'h10, 1'b0);
    wr("R8", 5'h10, 32'h0000_0100, 1'b0);

    // R4 enable-clear write stops the count
    wr("R4", 5'h04, 32'd10, 1'b0);
    wr("R4", 5'h00, 32'h0000_0082, 1'b0);
    run_rd("R4", 5'h08, 3);
    wr("R4", 5'h00, 32'h0000_0002, 1'b1);
    run_rd("R4", 5'h08, 3);

    // R3 expiry in the same cycle as a clearing write keeps the flag
    wr("R3", 5'h04, 32'd0, 1'b0);
    wr("R3", 5'h00, 32'h0000_00C2, 1'b0);
    wr("R3", 5'h00, 32'h0000_01C2, 1'b1);
    rd("R3", 5'h00, 1'b0);
    rd("R8", 5'h08, 1'b0);

    finish_run();
  end

endmodule